// File: doc/BRIEF.md
# Oversampled Serial Receiver with Clear-on-Read Status

This block recovers bytes from an asynchronous serial line and presents them, together with an eight-bit status byte, on a small read-only register port. The serial input is first synchronised. It is then sampled on a one-cycle enable pulse that the surrounding logic provides at sixteen times the bit rate. A frame is a low start bit, then the data bits with the least significant bit first, then an optional parity bit, then one or two high stop bits. Static inputs choose whether parity is used, whether it is even or odd, and how many stop bits are expected.

Each complete frame either loads the receive data register or, when that register still holds an unread byte, raises an overrun. Frame errors are kept as sticky flags. A read of the data register consumes the byte and clears the receive flags. The overrun flag survives that read if a byte was still pending, so software sees the loss once and only clears it with a later read. The transmit-side status bits are reported as idle, and the lowest status bit mirrors a clear-to-send pin.

Top module: `uart_rx_stat`

## Requirements
- R1: After reset the status byte reads 0x06 with bit 0 equal to the cts_pin level. Its bits are, from bit 7 down: data available, parity error, overrun, framing error, break, transmit register empty (1), transmitter empty (1), clear-to-send.
- R2: A frame that starts with a low start bit lasting at least half a bit time loads its data bits, least significant bit first, into the data register and sets the data-available bit. rd_addr 0 selects the data register and rd_addr 1 selects the status byte. rd_data is combinational from the address.
- R3: A read of the data register (rd_en high, rd_addr 0, at a clock edge) clears data available, parity error, framing error and break. The data register keeps its contents.
- R4: With par_en high, a parity bit follows the data. The parity error flag is set when the count of ones across the data and parity bits is odd (par_odd low) or even (par_odd high). With par_en low, no parity bit is taken and the flag is never set.
- R5: A frame that completes while a byte is held and not read in that same cycle sets overrun. The new byte is discarded and the held byte stays. The error flags of the discarded frame are not recorded.
- R6: A data register read clears overrun only if data available was 0 before the read. Otherwise overrun stays set.
- R7: The framing error flag is set when any expected stop bit samples low. With two_stop high, a low second stop bit sets it even when the first is high.
- R8: The break flag is set, together with the framing error flag, when every data bit, the parity bit (if enabled) and every stop bit sample low.
- R9: A low pulse on the line shorter than half a bit time is discarded and loads nothing.
- R10: When a frame completes in the same cycle as a data register read, the read returns the old byte and the new byte is loaded. Data available stays 1 and no overrun is raised. Completion is registered 155 cycles after the start bit is applied when the enable pulse is present every cycle, with no parity and one stop bit.
- R11: Status bit 0 follows cts_pin with no delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rxd | input | 1 | Serial receive line, idle high |
| os_tick | input | 1 | Sampling enable pulse at sixteen times the bit rate |
| par_en | input | 1 | Parity bit present |
| par_odd | input | 1 | 1 selects odd parity, 0 even |
| two_stop | input | 1 | 1 expects two stop bits |
| cts_pin | input | 1 | Clear-to-send pin, mirrored in status bit 0 |
| rd_en | input | 1 | Register read strobe |
| rd_addr | input | 1 | 0 data register, 1 status byte |
| rd_data | output | 8 | Read data |

## Verification
The hardest situation to reach is a data register read that falls on the exact cycle a frame completes while an older byte is still unread. A read one cycle early or late gives a plain load or an overrun instead. The bench counts clock edges from the moment it drives the start bit and issues the read on the completion edge given in R10. It then checks that the old byte was returned and the new one kept. Overrun persistence is reached by leaving one byte unread across a second frame and reading twice. Random frames vary parity mode, stop count and injected parity or stop faults.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_START = 3'd1,
        ST_DATA  = 3'd2,
        ST_PAR   = 3'd3,
        ST_STOP  = 3'd4
    } rx_state_e;

    localparam int unsigned STAT_W    = 8;
    localparam logic        ADDR_DATA = 1'b0;
    localparam logic        ADDR_STAT = 1'b1;

endpackage

// File: rtl/uart_rx_sync.sv
module uart_rx_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] sh_d, sh_q;

    always_comb begin
        sh_d = {sh_q[STAGES-2:0], din};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '1;
        else        sh_q <= sh_d;
    end

    assign dout = sh_q[STAGES-1];
endmodule

// File: rtl/uart_rx_frame.sv
module uart_rx_frame
    import uart_rx_pkg::*;
#(
    parameter int unsigned DATA_W  = 8,
    parameter int unsigned OS_RATE = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rxd_s,
    input  logic              tick,
    input  logic              par_en,
    input  logic              par_odd,
    input  logic              two_stop,
    output logic              done_o,
    output logic [DATA_W-1:0] data_o,
    output logic              pe_o,
    output logic              fe_o,
    output logic              brk_o
);
    localparam int unsigned CNT_W = $clog2(OS_RATE);
    localparam int unsigned BIT_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;
    localparam logic [CNT_W-1:0] CNT_HALF = CNT_W'(OS_RATE / 2 - 1);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(OS_RATE - 1);
    localparam logic [BIT_W-1:0] BIT_LAST = BIT_W'(DATA_W - 1);

    typedef struct packed {
        rx_state_e         state;
        logic [CNT_W-1:0]  cnt;
        logic [BIT_W-1:0]  bidx;
        logic [DATA_W-1:0] shreg;
        logic              all_zero;
        logic              perr;
        logic              stop_second;
        logic              ferr;
        logic              done;
        logic [DATA_W-1:0] dout;
        logic              pe;
        logic              fe;
        logic              brk;
    } frame_s;

    frame_s d, q;
    logic   fe_now, zero_now;

    always_comb begin
        d        = q;
        d.done   = 1'b0;
        fe_now   = q.ferr | ~rxd_s;
        zero_now = q.all_zero & ~rxd_s;
        unique case (q.state)
            ST_IDLE: begin
                if (tick && !rxd_s) begin
                    d.state = ST_START;
                    d.cnt   = '0;
                end
            end
            ST_START: begin
                if (tick) begin
                    if (q.cnt == CNT_HALF) begin
                        d.cnt = '0;
                        if (!rxd_s) begin
                            d.state       = ST_DATA;
                            d.bidx        = '0;
                            d.all_zero    = 1'b1;
                            d.perr        = 1'b0;
                            d.ferr        = 1'b0;
                            d.stop_second = 1'b0;
                        end else begin
                            d.state = ST_IDLE;
                        end
                    end else begin
                        d.cnt = q.cnt + 1'b1;
                    end
                end
            end
            ST_DATA: begin
                if (tick) begin
                    if (q.cnt == CNT_LAST) begin
                        d.cnt      = '0;
                        d.shreg    = {rxd_s, q.shreg[DATA_W-1:1]};
                        d.all_zero = zero_now;
                        if (q.bidx == BIT_LAST) d.state = par_en ? ST_PAR : ST_STOP;
                        else                    d.bidx  = q.bidx + 1'b1;
                    end else begin
                        d.cnt = q.cnt + 1'b1;
                    end
                end
            end
            ST_PAR: begin
                if (tick) begin
                    if (q.cnt == CNT_LAST) begin
                        d.cnt      = '0;
                        d.perr     = (^q.shreg) ^ rxd_s ^ par_odd;
                        d.all_zero = zero_now;
                        d.state    = ST_STOP;
                    end else begin
                        d.cnt = q.cnt + 1'b1;
                    end
                end
            end
            ST_STOP: begin
                if (tick) begin
                    if (q.cnt == CNT_LAST) begin
                        d.cnt = '0;
                        if (two_stop && !q.stop_second) begin
                            d.stop_second = 1'b1;
                            d.ferr        = fe_now;
                            d.all_zero    = zero_now;
                        end else begin
                            d.done  = 1'b1;
                            d.dout  = q.shreg;
                            d.pe    = par_en & q.perr;
                            d.fe    = fe_now;
                            d.brk   = zero_now;
                            d.state = ST_IDLE;
                        end
                    end else begin
                        d.cnt = q.cnt + 1'b1;
                    end
                end
            end
            default: d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign done_o = q.done;
    assign data_o = q.dout;
    assign pe_o   = q.pe;
    assign fe_o   = q.fe;
    assign brk_o  = q.brk;

    assert_brk_fe_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && brk_o) |-> fe_o);

    assert_done_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    assert_start_reject_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (q.state == ST_START && tick && q.cnt == CNT_HALF && rxd_s) |=> (q.state == ST_IDLE));
endmodule

// File: rtl/uart_rx_regs.sv
module uart_rx_regs #(
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              done_i,
    input  logic [DATA_W-1:0] fdata_i,
    input  logic              fpe_i,
    input  logic              ffe_i,
    input  logic              fbrk_i,
    input  logic              rd_stb_i,
    output logic              rda_o,
    output logic              pe_o,
    output logic              ovr_o,
    output logic              fe_o,
    output logic              brk_o,
    output logic [DATA_W-1:0] data_o
);
    typedef struct packed {
        logic              rda;
        logic              pe;
        logic              ovr;
        logic              fe;
        logic              brk;
        logic [DATA_W-1:0] data;
    } regs_s;

    regs_s d, q;
    logic  held;

    always_comb begin
        d    = q;
        held = q.rda & ~rd_stb_i;
        if (rd_stb_i) begin
            d.rda = 1'b0;
            d.pe  = 1'b0;
            d.fe  = 1'b0;
            d.brk = 1'b0;
            if (!q.rda) d.ovr = 1'b0;
        end
        if (done_i) begin
            if (held) begin
                d.ovr = 1'b1;
            end else begin
                d.data = fdata_i;
                d.rda  = 1'b1;
                d.pe   = d.pe  | fpe_i;
                d.fe   = d.fe  | ffe_i;
                d.brk  = d.brk | fbrk_i;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign rda_o  = q.rda;
    assign pe_o   = q.pe;
    assign ovr_o  = q.ovr;
    assign fe_o   = q.fe;
    assign brk_o  = q.brk;
    assign data_o = q.data;

    assert_rda_set_R2: assert property (@(posedge clk) disable iff (!rst_n)
        done_i |=> rda_o);

    assert_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_stb_i && !done_i) |=> (!rda_o && !pe_o && !fe_o && !brk_o));

    assert_ovr_keep_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (done_i && rda_o && !rd_stb_i) |=> (ovr_o && $stable(data_o)));

    assert_ovr_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_stb_i && rda_o && ovr_o) |=> ovr_o);

    assert_load_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (done_i && rd_stb_i) |=> (rda_o && data_o == $past(fdata_i)));
endmodule

// File: rtl/uart_rx_stat.sv
module uart_rx_stat
    import uart_rx_pkg::*;
#(
    parameter int unsigned DATA_W      = 8,
    parameter int unsigned OS_RATE     = 16,
    parameter int unsigned SYNC_STAGES = 2,
    localparam int unsigned BUS_W      = (DATA_W > STAT_W) ? DATA_W : STAT_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rxd,
    input  logic             os_tick,
    input  logic             par_en,
    input  logic             par_odd,
    input  logic             two_stop,
    input  logic             cts_pin,
    input  logic             rd_en,
    input  logic             rd_addr,
    output logic [BUS_W-1:0] rd_data
);
    logic              rxd_s;
    logic              f_done, f_pe, f_fe, f_brk;
    logic [DATA_W-1:0] f_data, held_data;
    logic              s_rda, s_pe, s_ovr, s_fe, s_brk;
    logic              rd_stb;
    logic [STAT_W-1:0] status;

    uart_rx_sync #(.STAGES(SYNC_STAGES)) sync_i (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (rxd),
        .dout (rxd_s)
    );

    uart_rx_frame #(.DATA_W(DATA_W), .OS_RATE(OS_RATE)) frame_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .rxd_s   (rxd_s),
        .tick    (os_tick),
        .par_en  (par_en),
        .par_odd (par_odd),
        .two_stop(two_stop),
        .done_o  (f_done),
        .data_o  (f_data),
        .pe_o    (f_pe),
        .fe_o    (f_fe),
        .brk_o   (f_brk)
    );

    assign rd_stb = rd_en && (rd_addr == ADDR_DATA);

    uart_rx_regs #(.DATA_W(DATA_W)) regs_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .done_i  (f_done),
        .fdata_i (f_data),
        .fpe_i   (f_pe),
        .ffe_i   (f_fe),
        .fbrk_i  (f_brk),
        .rd_stb_i(rd_stb),
        .rda_o   (s_rda),
        .pe_o    (s_pe),
        .ovr_o   (s_ovr),
        .fe_o    (s_fe),
        .brk_o   (s_brk),
        .data_o  (held_data)
    );

    assign status = {s_rda, s_pe, s_ovr, s_fe, s_brk, 1'b1, 1'b1, cts_pin};

    always_comb begin
        if (rd_addr == ADDR_STAT) rd_data = BUS_W'(status);
        else                      rd_data = BUS_W'(held_data);
    end
endmodule

// File: tb/uart_rx_stat_tb.sv
module uart_rx_stat_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rxd = 1'b1;
    logic       os_tick = 1'b1;
    logic       par_en = 1'b0;
    logic       par_odd = 1'b0;
    logic       two_stop = 1'b0;
    logic       cts_pin = 1'b0;
    logic       rd_en = 1'b0;
    logic       rd_addr = 1'b1;
    logic [7:0] rd_data;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    uart_rx_stat dut_i (
        .clk(clk), .rst_n(rst_n), .rxd(rxd), .os_tick(os_tick),
        .par_en(par_en), .par_odd(par_odd), .two_stop(two_stop),
        .cts_pin(cts_pin), .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data)
    );

    function automatic logic [7:0] exp_stat(logic rda, logic pe, logic ovr,
                                            logic fe, logic brk, logic cts);
        return {rda, pe, ovr, fe, brk, 1'b1, 1'b1, cts};
    endfunction

    function automatic logic par_bit(logic [7:0] b, logic odd, logic bad);
        return (^b) ^ odd ^ bad;
    endfunction

    task automatic chk(string req, logic [7:0] got, logic [7:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s got %02h expected %02h", req, got, exp);
        end
    endtask

    task automatic peek_stat(output logic [7:0] v);
        @(negedge clk);
        rd_addr = 1'b1;
        #1 v = rd_data;
    endtask

    task automatic read_data(output logic [7:0] v);
        @(negedge clk);
        rd_addr = 1'b0;
        rd_en   = 1'b1;
        #1 v = rd_data;
        @(negedge clk);
        rd_en   = 1'b0;
        rd_addr = 1'b1;
    endtask

    // caller is just after a rising edge; one bit lasts 16 cycles
    task automatic send_bits(logic [7:0] b, logic pen, logic podd, logic stop2,
                             logic bad_par, logic bad_stop);
        rxd = 1'b0;
        repeat (16) @(posedge clk);
        for (int i = 0; i < 8; i++) begin
            #1 rxd = b[i];
            repeat (16) @(posedge clk);
        end
        if (pen) begin
            #1 rxd = par_bit(b, podd, bad_par);
            repeat (16) @(posedge clk);
        end
        #1 rxd = !(bad_stop && !stop2);
        repeat (16) @(posedge clk);
        if (stop2) begin
            #1 rxd = !bad_stop;
            repeat (16) @(posedge clk);
        end
        #1 rxd = 1'b1;
        repeat (24) @(posedge clk);
    endtask

    task automatic send_frame(logic [7:0] b, logic pen, logic podd, logic stop2,
                              logic bad_par, logic bad_stop);
        par_en   = pen;
        par_odd  = podd;
        two_stop = stop2;
        @(posedge clk);
        #1;
        send_bits(b, pen, podd, stop2, bad_par, bad_stop);
    endtask

    logic [7:0] v;

    initial begin
        void'($urandom(32'h1a2b3c4d));
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1: reset values
        peek_stat(v);
        chk("R1 reset status", v, exp_stat(0, 0, 0, 0, 0, 0));

        // R11: cts mirror
        cts_pin = 1'b1;
        peek_stat(v);
        chk("R11 cts high", v, exp_stat(0, 0, 0, 0, 0, 1));
        cts_pin = 1'b0;
        peek_stat(v);
        chk("R11 cts low", v, exp_stat(0, 0, 0, 0, 0, 0));

        // R2: plain frame
        send_frame(8'hA5, 0, 0, 0, 0, 0);
        peek_stat(v);
        chk("R2 status after frame", v, exp_stat(1, 0, 0, 0, 0, 0));
        read_data(v);
        chk("R2 data byte", v, 8'hA5);
        // R3: cleared by the read
        peek_stat(v);
        chk("R3 status after read", v, exp_stat(0, 0, 0, 0, 0, 0));
        @(negedge clk);
        rd_addr = 1'b0;
        #1 chk("R3 data kept", rd_data, 8'hA5);

        // R9: short glitch ignored
        @(posedge clk);
        #1 rxd = 1'b0;
        repeat (4) @(posedge clk);
        #1 rxd = 1'b1;
        repeat (200) @(posedge clk);
        peek_stat(v);
        chk("R9 glitch status", v, exp_stat(0, 0, 0, 0, 0, 0));

        // R4: parity error, even and odd
        send_frame(8'h3C, 1, 0, 0, 1, 0);
        peek_stat(v);
        chk("R4 even bad parity", v, exp_stat(1, 1, 0, 0, 0, 0));
        read_data(v);
        chk("R4 data", v, 8'h3C);
        send_frame(8'h81, 1, 1, 0, 0, 0);
        peek_stat(v);
        chk("R4 odd good parity", v, exp_stat(1, 0, 0, 0, 0, 0));
        read_data(v);

        // R7: second stop low
        send_frame(8'h5A, 0, 0, 1, 0, 1);
        peek_stat(v);
        chk("R7 second stop low", v, exp_stat(1, 0, 0, 1, 0, 0));
        read_data(v);

        // R8: break
        send_frame(8'h00, 1, 0, 0, 0, 1);
        peek_stat(v);
        chk("R8 break with parity", v, exp_stat(1, 0, 0, 1, 1, 0));
        read_data(v);
        chk("R8 break data", v, 8'h00);
        peek_stat(v);
        chk("R3 break cleared", v, exp_stat(0, 0, 0, 0, 0, 0));

        // R5 / R6: overrun
        send_frame(8'h11, 0, 0, 0, 0, 0);
        send_frame(8'h22, 1, 0, 0, 1, 0);
        peek_stat(v);
        chk("R5 overrun status", v, exp_stat(1, 0, 1, 0, 0, 0));
        read_data(v);
        chk("R5 old byte kept", v, 8'h11);
        peek_stat(v);
        chk("R6 overrun survives", v, exp_stat(0, 0, 1, 0, 0, 0));
        read_data(v);
        peek_stat(v);
        chk("R6 overrun cleared", v, exp_stat(0, 0, 0, 0, 0, 0));

        // R10: read on the completion edge with a byte pending
        send_frame(8'h44, 0, 0, 0, 0, 0);
        @(posedge clk);
        #1;
        fork
            send_bits(8'h99, 0, 0, 0, 0, 0);
            begin
                repeat (155) @(posedge clk);
                #1 rd_addr = 1'b0;
                #1 chk("R10 read returns old", rd_data, 8'h44);
                rd_en = 1'b1;
                @(posedge clk);
                #1 rd_en = 1'b0;
                rd_addr = 1'b1;
            end
        join
        peek_stat(v);
        chk("R10 status", v, exp_stat(1, 0, 0, 0, 0, 0));
        read_data(v);
        chk("R10 new byte", v, 8'h99);

        // random frames
        for (int n = 0; n < 24; n++) begin
            logic [7:0] b;
            logic pen, podd, s2, bp, bs, brk, pbit;
            b    = 8'($urandom);
            if (n % 6 == 0) b = 8'h00;
            pen  = 1'($urandom);
            podd = 1'($urandom);
            s2   = 1'($urandom);
            bp   = pen && ($urandom % 4 == 0);
            bs   = ($urandom % 4 == 0);
            cts_pin = 1'($urandom);
            pbit = par_bit(b, podd, bp);
            brk  = (b == 8'h00) && (!pen || !pbit) && bs && !s2;
            send_frame(b, pen, podd, s2, bp, bs);
            peek_stat(v);
            chk("R2 R4 R7 R8 random status", v, exp_stat(1, bp, 0, bs, brk, cts_pin));
            read_data(v);
            chk("R2 random data", v, b);
            peek_stat(v);
            chk("R3 random cleared", v, exp_stat(0, 0, 0, 0, 0, cts_pin));
        end

        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog R2 got timeout expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule